// File: doc/BRIEF.md
# Register File With Program Counter at Address 1

This block is the architectural register store of a small processor core. It holds thirty-two word-sized entries selected by a five-bit index. Two read ports return data combinationally. One write port commits on the rising clock edge. Entry 0 is a constant zero source and sink.

Entry 1 is the program counter. Any ordinary writeback that names entry 1 is therefore a jump. The core also advances the counter through a dedicated next-address input and a step strobe. When a writeback to entry 1 and a step arrive in the same cycle, the writeback wins. A freeze input pins the counter and leaves writes to the other entries untouched.

Entries 2 and 3 are set aside for later architectural use but store data like any other entry. Entries 4 to 31 are intended for general data. The counter is also brought out on a separate port so that the core can fetch without spending a read port.

Top module: `pcreg_file`

## Requirements
- R1: The file has 32 entries addressed by 5 bits. Two read ports, A and B, each return the addressed entry in the same cycle, independently of each other.
- R2: Reading address 0 returns zero on both ports. A write to address 0 changes no entry and does not change the counter.
- R3: A write to an address from 2 to 31 is returned by both read ports from the cycle after the write edge. Entries that are not written keep their value.
- R4: With freeze low, a write to address 1 loads the written data into the counter at that edge. The new value is visible on `pc_o` in the next cycle.
- R5: When a write to address 1 and `pc_step_i` occur in the same cycle with freeze low, the counter takes the write data and not `pc_next_i`.
- R6: While `pc_freeze_i` is high, the counter keeps its value even when a step or a write to address 1 is presented. Writes to addresses 2 to 31 in the same cycle still take effect.
- R7: Reading address 1 on either port returns the current counter value, the same value that `pc_o` shows.
- R8: Reset (`rst_ni` low) clears every entry and the counter to zero.
- R9: With freeze low and no write to address 1, `pc_step_i` high loads `pc_next_i` into the counter. If `pc_step_i` is low, the counter holds.
- R10: Entries 2 and 3 behave as ordinary storage and follow R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, already synchronised to clk_i on release |
| rd_a_addr_i | input | 5 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 5 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 5 | Write index |
| wr_data_i | input | 32 | Write data |
| pc_next_i | input | 32 | Counter value to load on a step |
| pc_step_i | input | 1 | Step strobe for the counter |
| pc_freeze_i | input | 1 | Hold the counter at its current value |
| pc_o | output | 32 | Current counter value |

## Verification
Read data is combinational, so a read result is due in the same cycle as its address. A write, jump or step is due exactly one edge after it is presented. The bench therefore changes its inputs 1 ns after a rising edge, lets the reads settle, and compares them before the next edge. For a write, it compares on the first settled point after the next edge, where an expected image of all 32 entries and the counter has been updated. Sweeps over every address keep all update strobes low, so the edges they span cannot change state.

// File: rtl/pcreg_pkg.sv
package pcreg_pkg;
  // Architectural indices with fixed meaning
  localparam int unsigned ZERO_IDX = 0;
  localparam int unsigned PC_IDX   = 1;
  localparam int unsigned GPR_BASE = 2; // first index backed by plain storage

  // Source selected for the counter on a given edge
  typedef enum logic [1:0] {
    PC_SRC_HOLD = 2'd0,
    PC_SRC_JUMP = 2'd1,
    PC_SRC_STEP = 2'd2
  } pc_src_e;
endpackage

// File: rtl/pcreg_pc_unit.sv
module pcreg_pc_unit
  import pcreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freeze_i,
  input  logic              jump_i,
  input  logic [DATA_W-1:0] jump_data_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] step_data_i,
  output logic [DATA_W-1:0] pc_o
);
  pc_src_e           src;
  logic [DATA_W-1:0] pc_d;
  logic [DATA_W-1:0] pc_q;
  logic              pc_en;

  // Explicit writeback outranks the step; freeze outranks both.
  always_comb begin
    src = PC_SRC_HOLD;
    if (!freeze_i) begin
      if (jump_i)      src = PC_SRC_JUMP;
      else if (step_i) src = PC_SRC_STEP;
    end
  end

  always_comb begin
    pc_en = 1'b1;
    pc_d  = pc_q;
    unique case (src)
      PC_SRC_JUMP: pc_d = jump_data_i;
      PC_SRC_STEP: pc_d = step_data_i;
      default:     pc_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pcreg_gpr_bank.sv
module pcreg_gpr_bank
  import pcreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [(1<<ADDR_W)-1:0][DATA_W-1:0] regs_o
);
  localparam int unsigned NREGS = 1 << ADDR_W;

  for (genvar i = 0; i < NREGS; i++) begin : g_ent
    if (i < GPR_BASE) begin : g_none
      // Indices below the base are served elsewhere.
      assign regs_o[i] = '0;
    end else begin : g_store
      logic              hit;
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] d;

      assign hit = wr_en_i && (wr_addr_i == ADDR_W'(i));

      always_comb begin
        d = q;
        if (hit) d = wr_data_i;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  q <= '0;
        else if (hit) q <= d;
      end

      assign regs_o[i] = q;
    end
  end
endmodule

// File: rtl/pcreg_read_port.sv
module pcreg_read_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [(1<<ADDR_W)-1:0][DATA_W-1:0] view_i,
  output logic [DATA_W-1:0]                  data_o
);
  assign data_o = view_i[addr_i];
endmodule

// File: rtl/pcreg_file.sv
module pcreg_file
  import pcreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [ADDR_W-1:0] rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] pc_next_i,
  input  logic              pc_step_i,
  input  logic              pc_freeze_i,
  output logic [DATA_W-1:0] pc_o
);
  localparam int unsigned NREGS = 1 << ADDR_W;

  logic [NREGS-1:0][DATA_W-1:0] bank;
  logic [NREGS-1:0][DATA_W-1:0] view;
  logic [DATA_W-1:0]            pc_q;
  logic                         pc_wr;

  assign pc_wr = wr_en_i && (wr_addr_i == ADDR_W'(PC_IDX));

  pcreg_pc_unit #(.DATA_W(DATA_W)) u_pc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .freeze_i    (pc_freeze_i),
    .jump_i      (pc_wr),
    .jump_data_i (wr_data_i),
    .step_i      (pc_step_i),
    .step_data_i (pc_next_i),
    .pc_o        (pc_q)
  );

  pcreg_gpr_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .regs_o    (bank)
  );

  // Overlay the constant zero and the counter onto the stored entries.
  always_comb begin
    view           = bank;
    view[ZERO_IDX] = '0;
    view[PC_IDX]   = pc_q;
  end

  pcreg_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .addr_i (rd_a_addr_i),
    .view_i (view),
    .data_o (rd_a_data_o)
  );

  pcreg_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .addr_i (rd_b_addr_i),
    .view_i (view),
    .data_o (rd_b_data_o)
  );

  assign pc_o = pc_q;
endmodule

// File: rtl/pcreg_file_chk.sv
module pcreg_file_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] rd_a_addr_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [ADDR_W-1:0] rd_b_addr_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] pc_next_i,
  input logic              pc_step_i,
  input logic              pc_freeze_i,
  input logic [DATA_W-1:0] pc_o
);
  logic pc_wr;
  assign pc_wr = wr_en_i && (wr_addr_i == ADDR_W'(1));

  AST_ZERO_READ_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == '0) |-> (rd_a_data_o == '0)); // R2
  AST_ZERO_READ_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_addr_i == '0) |-> (rd_b_data_o == '0)); // R2
  AST_PC_ALIAS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == ADDR_W'(1)) |-> (rd_a_data_o == pc_o)); // R7
  AST_PC_ALIAS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_addr_i == ADDR_W'(1)) |-> (rd_b_data_o == pc_o)); // R7
  AST_PC_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr && !pc_freeze_i) |=> (pc_o == $past(wr_data_i))); // R4
  AST_JUMP_BEATS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr && pc_step_i && !pc_freeze_i) |=> (pc_o == $past(wr_data_i))); // R5
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_step_i && !pc_wr && !pc_freeze_i) |=> (pc_o == $past(pc_next_i))); // R9
  AST_PC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_freeze_i |=> $stable(pc_o)); // R6
  AST_PC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_step_i && !pc_wr) |=> $stable(pc_o)); // R9
  AST_WRITE_VISIBLE_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i > ADDR_W'(1)) |=>
      ((rd_a_addr_i != $past(wr_addr_i)) || (rd_a_data_o == $past(wr_data_i)))); // R3
endmodule

bind pcreg_file pcreg_file_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_pcreg_file.sv
`timescale 1ns/1ps
module sim_pcreg_file;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [4:0]  rd_a_addr_i, rd_b_addr_i, wr_addr_i;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i, pc_next_i, pc_o;
  logic        wr_en_i, pc_step_i, pc_freeze_i;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  logic [31:0] mem [32];
  logic [31:0] pcm;

  always #5 clk_i = ~clk_i;

  pcreg_file u0 (.*);

  function automatic logic [31:0] exp_of(input int a);
    if (a == 0)      return 32'h0;
    else if (a == 1) return pcm;
    else             return mem[a];
  endfunction

  function automatic logic [31:0] pat(input int a, input int s);
    return (32'h9E37_79B9 * (a + 1)) ^ (32'h0F0F_0000 + s);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Present read addresses and compare both ports (strobes must be idle).
  task automatic chk_rd(input int a, input string tag);
    rd_a_addr_i = 5'(a);
    rd_b_addr_i = 5'(31 - a);
    #1;
    chk(tag, rd_a_data_o, exp_of(a));
    chk(tag, rd_b_data_o, exp_of(31 - a));
  endtask

  // Apply one cycle of strobes; update the expected image at the edge.
  task automatic tick(input logic we, input int wa, input logic [31:0] wd,
                      input logic st, input logic [31:0] nx, input logic fz);
    wr_en_i = we; wr_addr_i = 5'(wa); wr_data_i = wd;
    pc_step_i = st; pc_next_i = nx; pc_freeze_i = fz;
    @(posedge clk_i);
    if (!fz && we && wa == 1) pcm = wd;
    else if (!fz && st)       pcm = nx;
    if (we && wa >= 2)        mem[wa] = wd;
    #1;
    wr_en_i = 1'b0; pc_step_i = 1'b0; pc_freeze_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    rd_a_addr_i = '0; rd_b_addr_i = '0;
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    pc_next_i = '0; pc_step_i = 1'b0; pc_freeze_i = 1'b0;
    for (int i = 0; i < 32; i++) mem[i] = '0;
    pcm = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R8: everything zero out of reset
    for (int a = 0; a < 32; a++) chk_rd(a, "R8");
    chk("R8 pc", pc_o, 32'h0);

    // R3 / R10: write each stored entry, read it on the next cycle
    for (int a = 2; a < 32; a++) begin
      tick(1'b1, a, pat(a, 0), 1'b0, '0, 1'b0);
      chk_rd(a, (a < 4) ? "R10" : "R3");
    end
    // R1: full sweep on both ports
    for (int a = 0; a < 32; a++) chk_rd(a, "R1");

    // R2: write to address 0 is ignored
    tick(1'b1, 0, 32'hFFFF_FFFF, 1'b0, '0, 1'b0);
    for (int a = 0; a < 32; a++) chk_rd(a, "R2");
    chk("R2 pc", pc_o, pcm);

    // R9 / R7: stepping the counter
    for (int k = 0; k < 8; k++) begin
      tick(1'b0, 0, '0, 1'b1, pcm + 32'd4, 1'b0);
      chk("R9 step", pc_o, 32'(4 * (k + 1)));
      chk_rd(1, "R7");
    end
    tick(1'b0, 0, '0, 1'b0, 32'hDEAD_0000, 1'b0);
    chk("R9 hold", pc_o, 32'd32);

    // R4: jump by ordinary write
    tick(1'b1, 1, 32'h0000_0100, 1'b0, '0, 1'b0);
    chk("R4", pc_o, 32'h0000_0100);
    chk_rd(1, "R7");

    // R5: write beats step
    tick(1'b1, 1, 32'h0000_2000, 1'b1, 32'h0000_0055, 1'b0);
    chk("R5", pc_o, 32'h0000_2000);

    // R6: freeze holds against step and jump; other writes land
    tick(1'b0, 0, '0, 1'b1, 32'h0000_0077, 1'b1);
    chk("R6 step", pc_o, 32'h0000_2000);
    tick(1'b1, 1, 32'h1234_5678, 1'b1, 32'h0000_0077, 1'b1);
    chk("R6 jump", pc_o, 32'h0000_2000);
    tick(1'b1, 7, 32'hCAFE_F00D, 1'b1, 32'h0000_0077, 1'b1);
    chk("R6 pc", pc_o, 32'h0000_2000);
    chk_rd(7, "R6");
    for (int a = 0; a < 32; a++) chk_rd(a, "R3");

    // R8: reset again clears everything
    rst_ni = 1'b0;
    #1;
    for (int i = 0; i < 32; i++) mem[i] = '0;
    pcm = '0;
    for (int a = 0; a < 32; a++) chk_rd(a, "R8");
    chk("R8 pc", pc_o, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule